// File: doc/BRIEF.md
# PLL Configuration Register Interlock

This block holds the configuration of a clock-generation PLL: a PLL power-up bit, a bit that selects the VCO clock as the base clock, a VCO power-range field E, a 12-bit multiplier N stored as two bytes, and a VCO range value L. Software writes these registers over a simple byte bus. The block stores the values and turns them into an effective PLL enable, an effective VCO select and an effective multiplier. These drive the clock switch and the PLL.

Not every write to the two control bits is allowed. The VCO can be chosen only while the PLL is powered. The PLL cannot be powered down while the VCO is chosen. A single write cannot flip both bits at once. The block refuses any write that breaks this order. Two register values have a special meaning at the outputs. A multiplier of zero is used as one. A range value of zero shuts the PLL off and forces the crystal clock. Reads always return the stored register contents.

Top module: `pllc_top`

## Requirements
- R1: A control write that would set the VCO-select bit (bit 6 of address 0) while the stored PLL-on bit (bit 7) is clear leaves the select bit clear.
- R2: A control write that would clear the PLL-on bit while the stored select bit is set leaves the PLL-on bit set.
- R3: A control write that requests a change of both bits applies the PLL-on change only if it is legal on its own (per R2), and always keeps the old select bit.
- R4: The multiplier N is formed from address 1 bits [3:0] (N[11:8]) and address 2 (N[7:0]). `mult_eff` equals N, except that N = 0 drives 1.
- R5: While L (address 3) is zero, `pll_enable` and `vco_select` are both 0, whatever the stored control bits are.
- R6: `pll_enable` equals the stored PLL-on bit AND (L != 0). `vco_select` equals the stored select bit AND the stored PLL-on bit AND (L != 0). Both reflect a write in the cycle after the write edge.
- R7: After reset: PLL off, crystal selected, E = 0, N = 0x030, L = 0x40.
- R8: `rd_data` returns the stored values at the read address. Address 0 reads {on, sel, 4'b0, E}. Address 1 reads {4'b0, N[11:8]}. Address 2 reads N[7:0]. Address 3 reads L. Addresses 4 to 7 read 0, and writes to them change nothing.
- R9: Control write bits [1:0] store E, and E drives `range_e` unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Stored contents at `rd_addr` (combinational) |
| pll_enable | output | 1 | Effective PLL power enable |
| vco_select | output | 1 | Effective base-clock select, 1 = VCO |
| mult_eff | output | 12 | Effective multiplier for the feedback divider |
| range_e | output | 2 | VCO power-range field |
| range_l | output | 8 | VCO range value |

## Verification
The risky internal state is a select bit that is set while the PLL-on bit is clear. If that state ever arose, it would show on the very next read of address 0. It would also show on `vco_select` as soon as the PLL-on bit was later set, handing the clock switch a VCO that never went through a legal ordering. A wrong resolution of a combined write shows one cycle after the write edge, both in the control readback and in the two effective outputs. The bench therefore checks every output and every register after each single write. This ties each fault to the write that caused it.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

    localparam int ADDR_W = 3;

    // Register addresses; the order is fixed only by the bus map
    localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MULT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_MULT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_RANGE   = 3'd3;

    // Control register bit positions
    localparam int CTRL_ON_BIT  = 7;
    localparam int CTRL_SEL_BIT = 6;

    typedef struct packed {
        logic pll_on;
        logic vco_sel;
    } ctrl_bits_t;

endpackage

// File: rtl/pllc_interlock.sv
module pllc_interlock
    import pllc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic wr_on,
    input  logic wr_sel,
    output logic on_q,
    output logic sel_q
);

    ctrl_bits_t st_d, st_q;
    logic       on_req, sel_req, on_ok, sel_ok;

    always_comb begin
        st_d    = st_q;
        on_req  = wr_ctrl && (wr_on != st_q.pll_on);
        sel_req = wr_ctrl && (wr_sel != st_q.vco_sel);
        // power-down only while VCO not chosen
        on_ok   = on_req && (wr_on || !st_q.vco_sel);
        // select may move alone, and may be set only with PLL powered
        sel_ok  = sel_req && !on_req && (!wr_sel || st_q.pll_on);
        if (on_ok)  st_d.pll_on  = wr_on;
        if (sel_ok) st_d.vco_sel = wr_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on_q  = st_q.pll_on;
    assign sel_q = st_q.vco_sel;

    AST_SEL_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vco_sel |-> st_q.pll_on);                                      // R1
    AST_SEL_RISE_AFTER_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.vco_sel) |-> $past(st_q.pll_on));                        // R1
    AST_ON_HELD_WHILE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pll_on && st_q.vco_sel) |=> st_q.pll_on);                     // R2
    AST_NO_DUAL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        !((st_q.pll_on != $past(st_q.pll_on)) &&
          (st_q.vco_sel != $past(st_q.vco_sel))));                          // R3

endmodule

// File: rtl/pllc_cfg_regs.sv
module pllc_cfg_regs
    import pllc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_W    = 12,
    parameter int E_W    = 2,
    parameter int L_W    = 8,
    parameter logic [N_W-1:0] N_RST = 12'h030,
    parameter logic [L_W-1:0] L_RST = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [E_W-1:0]    e_q,
    output logic [N_W-1:0]    n_q,
    output logic [L_W-1:0]    l_q
);

    localparam int NHI_W = N_W - DATA_W;

    typedef struct packed {
        logic [E_W-1:0] e;
        logic [N_W-1:0] n;
        logic [L_W-1:0] l;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                ADR_CTRL:    cfg_d.e                = wr_data[E_W-1:0];
                ADR_MULT_HI: cfg_d.n[N_W-1:DATA_W]  = wr_data[NHI_W-1:0];
                ADR_MULT_LO: cfg_d.n[DATA_W-1:0]    = wr_data;
                ADR_RANGE:   cfg_d.l                = wr_data[L_W-1:0];
                default:     cfg_d                  = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.e <= '0;
            cfg_q.n <= N_RST;
            cfg_q.l <= L_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign e_q = cfg_q.e;
    assign n_q = cfg_q.n;
    assign l_q = cfg_q.l;

    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > ADR_RANGE) |=> $stable(cfg_q));                 // R8

endmodule

// File: rtl/pllc_effective.sv
module pllc_effective #(
    parameter int N_W = 12,
    parameter int L_W = 8
) (
    input  logic           on_q,
    input  logic           sel_q,
    input  logic [N_W-1:0] n_q,
    input  logic [L_W-1:0] l_q,
    output logic           pll_enable,
    output logic           vco_select,
    output logic [N_W-1:0] mult_eff
);

    logic range_ok;

    always_comb begin
        range_ok   = (l_q != '0);
        pll_enable = on_q && range_ok;
        vco_select = sel_q && on_q && range_ok;
        mult_eff   = (n_q == '0) ? N_W'(1) : n_q;
    end

endmodule

// File: rtl/pllc_top.sv
module pllc_top
    import pllc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_W    = 12,
    parameter int E_W    = 2,
    parameter int L_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pll_enable,
    output logic              vco_select,
    output logic [N_W-1:0]    mult_eff,
    output logic [E_W-1:0]    range_e,
    output logic [L_W-1:0]    range_l
);

    localparam int NHI_W = N_W - DATA_W;

    logic           on_q, sel_q, wr_ctrl;
    logic [E_W-1:0] e_q;
    logic [N_W-1:0] n_q;
    logic [L_W-1:0] l_q;

    assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);

    pllc_interlock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_on   (wr_data[CTRL_ON_BIT]),
        .wr_sel  (wr_data[CTRL_SEL_BIT]),
        .on_q    (on_q),
        .sel_q   (sel_q)
    );

    pllc_cfg_regs #(
        .DATA_W (DATA_W),
        .N_W    (N_W),
        .E_W    (E_W),
        .L_W    (L_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .e_q     (e_q),
        .n_q     (n_q),
        .l_q     (l_q)
    );

    pllc_effective #(
        .N_W (N_W),
        .L_W (L_W)
    ) u_eff (
        .on_q       (on_q),
        .sel_q      (sel_q),
        .n_q        (n_q),
        .l_q        (l_q),
        .pll_enable (pll_enable),
        .vco_select (vco_select),
        .mult_eff   (mult_eff)
    );

    assign range_e = e_q;
    assign range_l = l_q;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL: begin
                rd_data[CTRL_ON_BIT]  = on_q;
                rd_data[CTRL_SEL_BIT] = sel_q;
                rd_data[E_W-1:0]      = e_q;
            end
            ADR_MULT_HI: rd_data[NHI_W-1:0] = n_q[N_W-1:DATA_W];
            ADR_MULT_LO: rd_data            = n_q[DATA_W-1:0];
            ADR_RANGE:   rd_data[L_W-1:0]   = l_q;
            default:     rd_data            = '0;
        endcase
    end

    AST_MULT_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mult_eff != '0);                                                    // R4
    AST_L_ZERO_FORCES_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (range_l == '0) |-> (!pll_enable && !vco_select));                  // R5
    AST_VCO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        vco_select |-> pll_enable);                                         // R6

endmodule

// File: tb/pllc_top_tb_top.sv
module pllc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        pll_enable, vco_select;
    logic [11:0] mult_eff;
    logic [1:0]  range_e;
    logic [7:0]  range_l;

    int n_chk = 0;
    int n_fail = 0;

    // bench model of stored state
    logic        m_on, m_sel;
    logic [1:0]  m_e;
    logic [11:0] m_n;
    logic [7:0]  m_l;

    always #10 clk = ~clk;   // 50 MHz

    pllc_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pll_enable(pll_enable), .vco_select(vco_select),
        .mult_eff(mult_eff), .range_e(range_e), .range_l(range_l)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_mult(input logic [11:0] n);
        return (n == 12'd0) ? 12'd1 : n;
    endfunction

    // control write rules taken from R1..R3
    task automatic model_ctrl(input logic won, input logic wsel, output string tag);
        logic on_chg, sel_chg;
        on_chg  = (won != m_on);
        sel_chg = (wsel != m_sel);
        tag = "R8";
        if (on_chg && sel_chg) begin
            tag = "R3";
            if (won || !m_sel) m_on = won;
        end else if (sel_chg) begin
            if (wsel && !m_on) tag = "R1";
            else m_sel = wsel;
        end else if (on_chg) begin
            if (!won && m_sel) tag = "R2";
            else m_on = won;
        end
    endtask

    task automatic check_all(input string tag);
        logic [7:0] exp_ctrl;
        chk("R6", "pll_enable", 32'(pll_enable), 32'(m_on && m_l != 0));
        chk("R6", "vco_select", 32'(vco_select), 32'(m_sel && m_on && m_l != 0));
        chk("R4", "mult_eff", 32'(mult_eff), 32'(exp_mult(m_n)));
        chk("R9", "range_e", 32'(range_e), 32'(m_e));
        chk("R8", "range_l", 32'(range_l), 32'(m_l));
        exp_ctrl = {m_on, m_sel, 4'b0, m_e};
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            case (a)
                0: chk(tag, "ctrl readback", 32'(rd_data), 32'(exp_ctrl));
                1: chk("R4", "N high readback", 32'(rd_data), 32'({4'b0, m_n[11:8]}));
                2: chk("R4", "N low readback", 32'(rd_data), 32'(m_n[7:0]));
                3: chk("R8", "L readback", 32'(rd_data), 32'(m_l));
                default: chk("R8", "unmapped readback", 32'(rd_data), 32'(0));
            endcase
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        string tag;
        tag = "R8";
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            3'd0: begin model_ctrl(d[7], d[6], tag); m_e = d[1:0]; end
            3'd1: m_n[11:8] = d[3:0];
            3'd2: m_n[7:0]  = d;
            3'd3: m_l       = d;
            default: ;
        endcase
        check_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_on = 0; m_sel = 0; m_e = 0; m_n = 12'h030; m_l = 8'h40;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R7 reset state
        chk("R7", "reset pll_enable", 32'(pll_enable), 32'(0));
        chk("R7", "reset vco_select", 32'(vco_select), 32'(0));
        chk("R7", "reset mult", 32'(mult_eff), 32'h030);
        chk("R7", "reset range_l", 32'(range_l), 32'h40);
        check_all("R7");

        // every start state crossed with every control write value
        for (int s = 0; s < 3; s++) begin
            for (int v = 0; v < 4; v++) begin
                do_reset();
                if (s >= 1) do_write(3'd0, 8'h80);
                if (s == 2) do_write(3'd0, 8'hC0);
                do_write(3'd0, {v[1], v[0], 4'b0, 2'(v + s)});
            end
        end

        // R4 zero multiplier, R5 zero range while VCO chosen
        do_reset();
        do_write(3'd0, 8'h80);
        do_write(3'd0, 8'hC3);
        do_write(3'd1, 8'h00);
        do_write(3'd2, 8'h00);
        chk("R4", "N=0 gives 1", 32'(mult_eff), 32'd1);
        do_write(3'd1, 8'hFA);
        do_write(3'd2, 8'h5C);
        chk("R4", "N split", 32'(mult_eff), 32'hA5C);
        do_write(3'd3, 8'h00);
        chk("R5", "L=0 pll_enable", 32'(pll_enable), 32'(0));
        chk("R5", "L=0 vco_select", 32'(vco_select), 32'(0));
        do_write(3'd0, 8'h00);   // R2 still refused with L=0
        do_write(3'd3, 8'h21);
        chk("R6", "VCO back after L", 32'(vco_select), 32'(1));
        // R8 unmapped writes ignored
        for (int a = 4; a < 8; a++) do_write(3'(a), 8'hFF);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] a;
            logic [7:0] d;
            a = ($urandom_range(0, 9) < 5) ? 3'd0 : 3'($urandom_range(1, 7));
            d = 8'($urandom);
            if (a == 3'd3 && $urandom_range(0, 5) == 0) d = 8'h00;
            if (a != 3'd0 && $urandom_range(0, 7) == 0) d = 8'h00;
            do_write(a, d);
            if ($urandom_range(0, 60) == 0) do_reset();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule